// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial bus slave that gives a host microcontroller access to a single 8-bit configuration and status register. It oversamples the bus clock and data lines with the system clock. It detects start and stop conditions and decodes a 7-bit device address. It accepts one data byte per write transaction and returns the register byte as many times as the host asks for it in a read. The bus is driven only through an open-drain pull-low enable.

The six upper register bits are control outputs for the neighbouring power and signalling logic. The two lower bits are never stored. On every read they carry two live fault flags from outside the block. A supply-lockout input keeps the register cleared and the slave silent for as long as it is asserted.

Top module: `twire_cfg_slave`

## Requirements
- R1: After reset, all six control bits are 0 and the slave does not pull SDA low.
- R2: The device address is the 5-bit prefix 00010 followed by the 2-bit strap input. The slave pulls SDA low in the ninth clock only for an address byte whose upper seven bits match. The least significant bit of the address byte selects the direction: 1 reads, 0 writes. On a mismatch the slave stays silent for the rest of the transaction and the register is unchanged.
- R3: In a write, the first data byte is acknowledged and its bits 7..2 become the control outputs ctrlBits[5..0]. Bit 7 is the static current-limit select, bit 6 the transmit-path enable, bit 5 the forced tone, bit 4 the line-drop boost, bit 3 the high-voltage select and bit 2 the power enable. The control outputs change only in the cycle after a data byte completes, or during lockout.
- R4: Bits 1..0 of a written byte are discarded and never appear on a read.
- R5: A read returns {ctrlBits[5:0], overTemp, overload}, MSB first. The two flags are taken from the status inputs at the moment the byte is loaded for shifting, which is the SCL falling edge that ends the preceding acknowledge.
- R6: If the host acknowledges a read byte, a freshly loaded byte follows. If the host does not acknowledge, the slave releases SDA and ignores further clocks until the next start.
- R7: A second data byte in the same write transaction is not acknowledged and does not change the register.
- R8: A start or stop condition in the middle of a byte aborts the transfer without changing the register. A start always begins a new address phase.
- R9: While uvLock is high, the control bits are forced to 0, SDA is never pulled low, and no address is acknowledged.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| uvLock | input | 1 | Supply lockout; high holds the register cleared and the slave silent |
| strapSel | input | 2 | Address strap; forms the two low address bits |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| statOverTemp | input | 1 | Live over-temperature flag, returned in read bit 1 |
| statOverload | input | 1 | Live overload flag, returned in read bit 0 |
| sdaPullLow | output | 1 | Open-drain enable; high pulls SDA low |
| ctrlBits | output | 6 | Stored control bits, register bits 7..2 |

## Verification
The bench aims at the edges of the byte protocol. It sends a second data byte in one write, which a design that kept shifting would accept and use to overwrite the register. It aborts a write with a stop or a repeated start after a few bits, which a design committing on partial data would turn into a register change. It changes the status flags between the address acknowledge and the data bits, which separates a design that samples them at load time from one that samples them bit by bit. It also covers strap-driven address changes, a NACK followed by stray clocks, and a write attempted under lockout, which a design that gated only the outputs would still store.

// File: rtl/twire_pkg.sv
package twire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WRITE_ACK,
    ST_READ,
    ST_READ_ACK
  } busState_t;

  // strobes from the protocol control to the datapath
  typedef struct packed {
    logic shiftIn;   // capture sampled SDA into the shifter
    logic loadRd;    // load register image for transmission
    logic shiftOut;  // advance transmit shifter by one bit
    logic commit;    // copy received byte into control bits
  } dpCmd_t;

endpackage

// File: rtl/twire_pin_filter.sv
module twire_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      histQ  <= '1;
      pinOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
      // output follows only a level held for the whole history window
      if (&histQ)       pinOut <= 1'b1;
      else if (~|histQ) pinOut <= 1'b0;
    end
  end

endmodule

// File: rtl/twire_ctrl.sv
module twire_ctrl
  import twire_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 2,
  parameter int ADDR_W  = 7,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b00010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               uvLock,
  input  logic               sclLvl,
  input  logic               sdaLvl,
  input  logic [STRAP_W-1:0] strapSel,
  input  logic [DATA_W-1:0]  shByte,
  output dpCmd_t             cmd,
  output logic               sdaPullLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  busState_t        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             sclPrev, sdaPrev;
  logic             rwQ, rwNext;
  logic             hostAck, hostAckNext;

  logic sclRise, sclFall, startCond, stopCond, addrHit;

  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startCond = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopCond  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign addrHit   = (shByte[DATA_W-1:1] == {ADDR_HI, strapSel});

  always_comb begin
    stNext      = state;
    cntNext     = bitCnt;
    rwNext      = rwQ;
    hostAckNext = hostAck;
    cmd         = '0;
    if (startCond) begin
      stNext  = ST_ADDR;
      cntNext = '0;
    end else if (stopCond) begin
      stNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WRITE: begin
          if (sclRise && bitCnt < LAST) begin
            cmd.shiftIn = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST) begin
            if (state == ST_WRITE) begin
              cmd.commit = 1'b1;
              stNext     = ST_WRITE_ACK;
            end else if (addrHit) begin
              stNext = ST_ADDR_ACK;
              rwNext = shByte[0];
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          cntNext = '0;
          if (rwQ) begin
            stNext     = ST_READ;
            cmd.loadRd = 1'b1;
          end else begin
            stNext = ST_WRITE;
          end
        end
        ST_WRITE_ACK: if (sclFall) stNext = ST_IDLE;
        ST_READ: begin
          if (sclRise && bitCnt < LAST)       cntNext = bitCnt + 1'b1;
          else if (sclFall && bitCnt == LAST) stNext = ST_READ_ACK;
          else if (sclFall)                   cmd.shiftOut = 1'b1;
        end
        ST_READ_ACK: begin
          if (sclRise) hostAckNext = ~sdaLvl;
          if (sclFall) begin
            if (hostAck) begin
              stNext     = ST_READ;
              cmd.loadRd = 1'b1;
              cntNext    = '0;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
    if (uvLock) begin
      stNext = ST_IDLE;
      cmd    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      rwQ     <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stNext;
      bitCnt  <= cntNext;
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
      rwQ     <= rwNext;
      hostAck <= hostAckNext;
    end
  end

  assign sdaPullLow = ~uvLock &
                      ((state == ST_ADDR_ACK) || (state == ST_WRITE_ACK) ||
                       ((state == ST_READ) && ~shByte[DATA_W-1]));

endmodule

// File: rtl/twire_dp.sv
module twire_dp
  import twire_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              uvLock,
  input  dpCmd_t            cmd,
  input  logic              sdaLvl,
  input  logic              statOverTemp,
  input  logic              statOverload,
  output logic [DATA_W-1:0] shByte,
  output logic [DATA_W-3:0] ctrlBits
);

  localparam int CTRL_W = DATA_W - 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shByte   <= '0;
      ctrlBits <= '0;
    end else begin
      if (uvLock)          ctrlBits <= '0;
      else if (cmd.commit) ctrlBits <= shByte[DATA_W-1 -: CTRL_W];

      if (cmd.shiftIn)       shByte <= {shByte[DATA_W-2:0], sdaLvl};
      else if (cmd.loadRd)   shByte <= {ctrlBits, statOverTemp, statOverload};
      else if (cmd.shiftOut) shByte <= {shByte[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/twire_cfg_slave.sv
module twire_cfg_slave
  import twire_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 2,
  parameter logic [DATA_W-1-STRAP_W-1:0] ADDR_HI = 5'b00010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               uvLock,
  input  logic [STRAP_W-1:0] strapSel,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               statOverTemp,
  input  logic               statOverload,
  output logic               sdaPullLow,
  output logic [DATA_W-3:0]  ctrlBits
);

  localparam int ADDR_W = DATA_W - 1;
  localparam int CTRL_W = DATA_W - 2;

  logic              sclF, sdaF;
  logic [DATA_W-1:0] shByte;
  dpCmd_t            dpCmd;

  twire_pin_filter uSclFilt (.clk(clk), .rstN(rstN), .pinIn(sclIn), .pinOut(sclF));
  twire_pin_filter uSdaFilt (.clk(clk), .rstN(rstN), .pinIn(sdaIn), .pinOut(sdaF));

  twire_ctrl #(
    .DATA_W(DATA_W), .STRAP_W(STRAP_W), .ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .uvLock(uvLock), .sclLvl(sclF), .sdaLvl(sdaF),
    .strapSel(strapSel), .shByte(shByte), .cmd(dpCmd), .sdaPullLow(sdaPullLow)
  );

  twire_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .uvLock(uvLock), .cmd(dpCmd), .sdaLvl(sdaF),
    .statOverTemp(statOverTemp), .statOverload(statOverload),
    .shByte(shByte), .ctrlBits(ctrlBits)
  );

endmodule

// File: rtl/twire_chk.sv
module twire_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          uvLock,
  input logic          sclLvl,
  input logic          sdaPullLow,
  input logic          commitStb,
  input logic [CW-1:0] ctrlBits
);

  p_quiet_in_lockout_r9: assert property (@(posedge clk) disable iff (!rstN)
    uvLock |-> !sdaPullLow);

  p_cleared_in_lockout_r9: assert property (@(posedge clk) disable iff (!rstN)
    uvLock |=> (ctrlBits == '0));

  p_drive_moves_low_scl_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !uvLock && !$past(uvLock)) |-> !sclLvl);

  p_ctrl_moves_on_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlBits) |-> ($past(commitStb) || $past(uvLock)));

endmodule

bind twire_cfg_slave twire_chk #(.CW(CTRL_W)) uChk (
  .clk(clk), .rstN(rstN), .uvLock(uvLock), .sclLvl(sclF),
  .sdaPullLow(sdaPullLow), .commitStb(dpCmd.commit), .ctrlBits(ctrlBits)
);

// File: tb/tb_twire_cfg_slave.sv
`timescale 1ns/1ps
module tb_twire_cfg_slave;

  localparam int Q    = 20;      // quarter bit in clocks
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       uvLock = 1'b0;
  logic [1:0] strapSel = 2'b00;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       statOverTemp = 1'b0, statOverload = 1'b0;
  logic       sdaPullLow;
  logic [5:0] ctrlBits;
  logic       sdaBus;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #2.5 clk = ~clk;

  twire_cfg_slave dut (
    .clk(clk), .rstN(rstN), .uvLock(uvLock), .strapSel(strapSel),
    .sclIn(sclM), .sdaIn(sdaBus), .statOverTemp(statOverTemp),
    .statOverload(statOverload), .sdaPullLow(sdaPullLow), .ctrlBits(ctrlBits)
  );

  int errors = 0, checks = 0, hiChange = 0;
  string      tagQ[$];
  logic [7:0] expQ[$];
  logic [7:0] obsQ[$];
  event       obsEv;

  function automatic void drain();
    while (obsQ.size() > 0 && expQ.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = expQ.pop_front();
      a = obsQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%02h expected=%02h", t, a, e);
      end
    end
  endfunction

  // driver side: expected items
  task automatic expectItem(input string t, input logic [7:0] e);
    tagQ.push_back(t);
    expQ.push_back(e);
  endtask

  task automatic observe(input logic [7:0] a);
    obsQ.push_back(a);
    ->obsEv;
  endtask

  task automatic chk(input string t, input logic [7:0] e, input logic [7:0] a);
    expectItem(t, e);
    observe(a);
  endtask

  // monitor: pops and compares
  initial forever begin
    @(obsEv);
    drain();
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b0; qwait();
    sclM = 1'b0; qwait();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qwait();
    sclM = 1'b1; qwait();
    sdaM = 1'b1; qwait();
  endtask

  task automatic busBit(input logic b, output logic got);
    sdaM = b; qwait();
    sclM = 1'b1; qwait();
    got = sdaBus; qwait();
    if (sdaBus !== got) hiChange++;
    sclM = 1'b0; qwait();
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    logic g;
    for (int i = 7; i > 7 - n; i--) busBit(v[i], g);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    sendBits(v, 8);
    busBit(1'b1, ack);
  endtask

  task automatic readByte(input logic hostAck, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, g);
      v[i] = g;
    end
    busBit(~hostAck, g);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk("R1 ctrl after reset", 8'h00, {2'b00, ctrlBits});
    chk("R1 sda released", 8'h00, {7'b0, sdaPullLow});

    // R3 single write, base address
    busStart();
    sendByte(8'h10, a); chk("R2 base addr ack", 8'h00, {7'b0, a});
    sendByte(8'hA7, a); chk("R3 data ack", 8'h00, {7'b0, a});
    busStop();
    chk("R3 ctrl after write", 8'h29, {2'b00, ctrlBits});

    // R5 read, status sampled at load; R6 host ack then nack
    statOverTemp = 1'b1; statOverload = 1'b0;
    busStart();
    sendByte(8'h11, a); chk("R2 read addr ack", 8'h00, {7'b0, a});
    statOverTemp = 1'b0; statOverload = 1'b1;   // after load of byte 1
    readByte(1'b1, v); chk("R5 first read byte", 8'hA6, v);
    readByte(1'b0, v); chk("R6 byte after host ack", 8'hA5, v);
    readByte(1'b0, v); chk("R6 silent after nack", 8'hFF, v);
    busStop();

    // R2 wrong address for strap 00
    busStart();
    sendByte(8'h12, a); chk("R2 mismatch nack", 8'h01, {7'b0, a});
    sendByte(8'h00, a); chk("R2 data after mismatch", 8'h01, {7'b0, a});
    busStop();
    chk("R2 ctrl unchanged", 8'h29, {2'b00, ctrlBits});

    // R2 strap 11 moves the address
    strapSel = 2'b11;
    busStart();
    sendByte(8'h16, a); chk("R2 strap addr ack", 8'h00, {7'b0, a});
    sendByte(8'hFC, a);
    busStop();
    chk("R2 ctrl via strap addr", 8'h3F, {2'b00, ctrlBits});
    busStart();
    sendByte(8'h10, a); chk("R2 old addr nack", 8'h01, {7'b0, a});
    busStop();

    // R7 second data byte
    busStart();
    sendByte(8'h16, a);
    sendByte(8'h54, a); chk("R7 first byte ack", 8'h00, {7'b0, a});
    sendByte(8'h08, a); chk("R7 second byte nack", 8'h01, {7'b0, a});
    busStop();
    chk("R7 ctrl keeps first byte", 8'h15, {2'b00, ctrlBits});

    // R8 stop mid-byte, then start mid-byte
    busStart();
    sendByte(8'h16, a);
    sendBits(8'h00, 4);
    busStop();
    chk("R8 ctrl after stop abort", 8'h15, {2'b00, ctrlBits});
    busStart();
    sendByte(8'h16, a);
    sendBits(8'hFF, 3);
    busStart();
    sendByte(8'h16, a); chk("R8 addr after restart", 8'h00, {7'b0, a});
    sendByte(8'h80, a);
    busStop();
    chk("R8 ctrl after restart write", 8'h20, {2'b00, ctrlBits});

    // R9 lockout
    uvLock = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 ctrl cleared", 8'h00, {2'b00, ctrlBits});
    busStart();
    sendByte(8'h16, a); chk("R9 no ack in lockout", 8'h01, {7'b0, a});
    sendByte(8'hFC, a);
    busStop();
    chk("R9 write ignored", 8'h00, {2'b00, ctrlBits});
    uvLock = 1'b0;
    statOverTemp = 1'b0; statOverload = 1'b0;
    repeat (5) @(negedge clk);
    busStart();
    sendByte(8'h17, a); chk("R9 ack after release", 8'h00, {7'b0, a});
    readByte(1'b0, v); chk("R9 register stayed clear", 8'h00, v);
    busStop();

    // R4 low bits of a write are dropped
    busStart();
    sendByte(8'h16, a);
    sendByte(8'h0F, a);
    busStop();
    chk("R4 ctrl from write", 8'h03, {2'b00, ctrlBits});
    statOverload = 1'b1;
    busStart();
    sendByte(8'h17, a);
    readByte(1'b0, v); chk("R4 status replaces low bits", 8'h0D, v);
    busStop();
    statOverload = 1'b0;
    busStart();
    sendByte(8'h17, a);
    readByte(1'b0, v); chk("R4 written low bits absent", 8'h0C, v);
    busStop();

    // R10 slave drive steady while SCL high
    chk("R10 changes while scl high", 8'h00, 8'(hiChange));

    repeat (5) @(negedge clk);
    drain();
    summary();
    $finish;
  end

endmodule